// File: doc/BRIEF.md
# Process Directory Walker

This block finds the process-context record for one transaction. It takes a 20-bit process identifier, the physical page number of the directory root, a depth mode and three flags. It then walks a one-, two- or three-level radix tree of 8-byte directory entries and reads the leaf record. The reads go out as single 64-bit requests on a memory port, one at a time. When the walk succeeds, the record's doublewords leave on a valid/ready stream in ascending address order. When the walk fails, no doublewords are sent and a fault cause is reported.

Two flags fix the layout of the directory. The first says the second-stage table pointer lives in the process context. The second says the context also carries flat MSI table fields. Together they set how the process identifier is split into per-level indices and how large the leaf record is. The third flag says that device-level second-stage translation is active. When that flag is set and the first flag is clear, every directory address is guest-physical. Each such address goes out on a translation port before it is read, and the returned address is used in its place.

The block accepts one walk at a time. It holds `busy` high from acceptance until its completion pulse.

Top module: `pdw_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle, `busy` is high and `req_ready` is low until the walk completes.
- R2: The number of directory levels comes from `req_mode`: 3 gives three levels, 2 gives two, and 1 or 0 gives one. A walk that completes without a fault makes (levels − 1) directory-entry reads plus the reads of the leaf record.
- R3: With both format flags clear, the identifier splits into index fields from the least significant bit upward: leaf index in bits 7:0, middle index in bits 16:8, top index in bits 19:17. The leaf record is 16 bytes, which is 2 doublewords.
- R4: With `req_s2_in_ctx`=1 and `req_msi_flat`=0, the split is leaf bits 6:0, middle bits 15:7, top bits 19:16. The record is 32 bytes, which is 4 doublewords.
- R5: With both flags set, the split is leaf bits 5:0, middle bits 14:6, top bits 19:15. The record is 64 bytes, which is 8 doublewords. `req_msi_flat` on its own, with `req_s2_in_ctx`=0, selects the layout of R3.
- R6: The walk starts with table base `req_root_ppn`×4096 at the top level. A directory entry is read at base + index×8, and its PPN becomes the base of the next lower level. The leaf record starts at base + leaf index × record size. Its doublewords are read at start + 8k.
- R7: A directory entry holds a valid flag in bit 0, reserved bits 9:1, the PPN in bits 53:10 and reserved bits 63:54. An entry whose valid bit is 0 stops the walk with cause 266.
- R8: A valid entry with any reserved bit set stops the walk with cause 267.
- R9: A read answered with `mem_rsp_err`=1, whether for a directory entry or for any leaf doubleword, stops the walk with cause 265.
- R10: When `req_s2_in_ctx`=0 and `req_s2_active`=1, each directory-entry address and the leaf record start address are sent on the translation port, and the returned address is read instead. Leaf doublewords are read at the translated start + 8k. In every other case the translation port is never used.
- R11: A translation response with `gpa_rsp_fault`=1 stops the walk with the cause given on `gpa_rsp_cause`.
- R12: Record doublewords go out on `ctx_*` only after the whole record has been read without error. They go out in ascending address order, with `ctx_last` set on the final one. While `ctx_ready` is low, data and last are held. A faulting walk sends no doublewords.
- R13: `walk_done` pulses for one cycle at the end of every walk. On success this is after the final doubleword has been accepted, with `walk_fault`=0 and `walk_cause`=0. On a fault it carries `walk_fault`=1 and the cause. The block is idle in the following cycle.
- R14: At most one memory read is outstanding, and the memory port accepts every response when it arrives. While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_pid | input | 20 | Process identifier |
| req_root_ppn | input | 44 | Page number of the root directory table |
| req_mode | input | 2 | Directory depth (3, 2, 1; 0 acts as 1) |
| req_s2_in_ctx | input | 1 | Second-stage pointer held in process context |
| req_msi_flat | input | 1 | Context also holds flat MSI table fields |
| req_s2_active | input | 1 | Device-level second-stage translation not Bare |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 56 | Physical byte address of the 64-bit read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Read data |
| mem_rsp_err | input | 1 | Read failed its access check |
| gpa_req_valid | output | 1 | Translation request |
| gpa_req_ready | input | 1 | Translator accepts the request |
| gpa_req_addr | output | 56 | Guest-physical address to translate |
| gpa_rsp_valid | input | 1 | Translation result present |
| gpa_rsp_addr | input | 56 | Translated physical address |
| gpa_rsp_fault | input | 1 | Translation failed |
| gpa_rsp_cause | input | 10 | Cause code of a failed translation |
| ctx_valid | output | 1 | Record doubleword present |
| ctx_ready | input | 1 | Consumer takes the doubleword |
| ctx_data | output | 64 | Record doubleword |
| ctx_last | output | 1 | Final doubleword of the record |
| walk_done | output | 1 | Walk complete (one-cycle pulse) |
| walk_fault | output | 1 | Walk ended with a fault |
| walk_cause | output | 10 | Fault cause, 0 on success |

## Verification
Two things can fall in the same cycle: the consumer holding back the final record doubleword, and the end of the walk. The completion pulse must wait until that doubleword has been taken. The bench drops `ctx_ready` at random on every cycle, so stalls on the last beat happen in many walks. The bench then judges the result by the number of beats received, the position of `ctx_last` and the fact that `walk_done` arrives only afterwards. Random stalls on both request ports also line up with response arrivals. This shows that a request is held stable while stalled and that no second read is issued before the first has been answered.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  localparam int CAUSE_W = 10;
  localparam int ENT_W   = 64;

  localparam logic [CAUSE_W-1:0] CAUSE_LOAD_FAULT = 10'd265;
  localparam logic [CAUSE_W-1:0] CAUSE_NOT_VALID  = 10'd266;
  localparam logic [CAUSE_W-1:0] CAUSE_MISCONFIG  = 10'd267;

  // record layout chosen by the two capability flags
  typedef enum logic [1:0] {
    FMT_BASE = 2'd0,
    FMT_EXT  = 2'd1,
    FMT_MSI  = 2'd2
  } fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XREQ,
    ST_XRSP,
    ST_MREQ,
    ST_MRSP,
    ST_EMIT,
    ST_FIN
  } wstate_e;

endpackage

// File: rtl/pdw_index.sv
module pdw_index #(
  parameter int PID_W = 20,
  parameter int PA_W  = 56,
  parameter int MID_W = 9
) (
  input  logic [PID_W-1:0] pid,
  input  pdw_pkg::fmt_e    fmt,
  input  logic [1:0]       lvl,
  input  logic [PA_W-1:0]  base,
  output logic [PA_W-1:0]  addr
);
  logic [4:0]       w_leaf;
  logic [4:0]       w_top;
  logic [PID_W-1:0] idx_leaf;
  logic [PID_W-1:0] idx_mid;
  logic [PID_W-1:0] idx_top;
  logic [PID_W-1:0] idx_dir;

  always_comb begin
    // leaf field narrows and top field widens as the record grows
    w_leaf   = 5'd8 - 5'(fmt);
    w_top    = 5'd3 + 5'(fmt);
    idx_leaf = pid & ~({PID_W{1'b1}} << w_leaf);
    idx_mid  = (pid >> w_leaf) & PID_W'((1 << MID_W) - 1);
    idx_top  = (pid >> (w_leaf + 5'(MID_W))) & ~({PID_W{1'b1}} << w_top);
    idx_dir  = (lvl == 2'd2) ? idx_top : idx_mid;
    if (lvl == 2'd0) addr = base + (PA_W'(idx_leaf) << (4 + 32'(fmt)));
    else             addr = base + (PA_W'(idx_dir) << 3);
  end

endmodule

// File: rtl/pdw_entry_chk.sv
module pdw_entry_chk #(
  parameter int ENT_W   = 64,
  parameter int PPN_W   = 44,
  parameter int PPN_LSB = 10
) (
  input  logic [ENT_W-1:0] entry,
  output logic [PPN_W-1:0] ppn,
  output logic             ent_valid,
  output logic             ent_rsvd
);
  localparam int PPN_MSB = PPN_LSB + PPN_W - 1;
  localparam logic [ENT_W-1:0] PPN_MASK =
    ({ENT_W{1'b1}} >> (ENT_W - 1 - PPN_MSB)) & ({ENT_W{1'b1}} << PPN_LSB);
  localparam logic [ENT_W-1:0] USED_MASK = PPN_MASK | ENT_W'(1);

  assign ent_valid = entry[0];
  assign ppn       = entry[PPN_MSB:PPN_LSB];
  assign ent_rsvd  = |(entry & ~USED_MASK);

endmodule

// File: rtl/pdw_recbuf.sv
module pdw_recbuf #(
  parameter int DEPTH = 8,
  parameter int W     = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IW'(g)) slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];

endmodule

// File: rtl/pdw_walker.sv
module pdw_walker #(
  parameter int PID_W   = 20,
  parameter int PPN_W   = 44,
  parameter int CAUSE_W = pdw_pkg::CAUSE_W,
  parameter int MAX_DW  = 8,
  localparam int PA_W   = PPN_W + 12,
  localparam int BW     = $clog2(MAX_DW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [PPN_W-1:0]   req_root_ppn,
  input  logic [1:0]         req_mode,
  input  logic               req_s2_in_ctx,
  input  logic               req_msi_flat,
  input  logic               req_s2_active,
  output logic               busy,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  input  logic               mem_rsp_err,
  output logic               gpa_req_valid,
  input  logic               gpa_req_ready,
  output logic [PA_W-1:0]    gpa_req_addr,
  input  logic               gpa_rsp_valid,
  input  logic [PA_W-1:0]    gpa_rsp_addr,
  input  logic               gpa_rsp_fault,
  input  logic [CAUSE_W-1:0] gpa_rsp_cause,
  output logic               ctx_valid,
  input  logic               ctx_ready,
  output logic [63:0]        ctx_data,
  output logic               ctx_last,
  output logic               walk_done,
  output logic               walk_fault,
  output logic [CAUSE_W-1:0] walk_cause
);
  import pdw_pkg::*;

  wstate_e            st_q;
  logic [PID_W-1:0]   pid_q;
  fmt_e               fmt_q;
  logic               xl_q;
  logic [1:0]         lvl_q;
  logic [PA_W-1:0]    base_q;
  logic [PA_W-1:0]    addr_q;
  logic [BW-1:0]      beat_q;
  logic               fault_q;
  logic [CAUSE_W-1:0] cause_q;

  logic [PA_W-1:0]    tgt_addr;
  logic [PPN_W-1:0]   ent_ppn;
  logic               ent_valid;
  logic               ent_rsvd;
  logic [BW-1:0]      last_beat;
  logic               buf_wr;
  logic [63:0]        buf_rd;
  fmt_e               fmt_in;
  logic               xl_in;
  logic [1:0]         lvl_in;
  logic               next_xl;

  pdw_index #(.PID_W(PID_W), .PA_W(PA_W)) u_index (
    .pid  (pid_q),
    .fmt  (fmt_q),
    .lvl  (lvl_q),
    .base (base_q),
    .addr (tgt_addr)
  );

  pdw_entry_chk #(.ENT_W(ENT_W), .PPN_W(PPN_W)) u_entry (
    .entry     (mem_rsp_data),
    .ppn       (ent_ppn),
    .ent_valid (ent_valid),
    .ent_rsvd  (ent_rsvd)
  );

  pdw_recbuf #(.DEPTH(MAX_DW), .W(64)) u_buf (
    .clk     (clk),
    .wr_en   (buf_wr),
    .wr_idx  (beat_q),
    .wr_data (mem_rsp_data),
    .rd_idx  (beat_q),
    .rd_data (buf_rd)
  );

  always_comb begin
    if (!req_s2_in_ctx)    fmt_in = FMT_BASE;
    else if (req_msi_flat) fmt_in = FMT_MSI;
    else                   fmt_in = FMT_EXT;
    xl_in     = !req_s2_in_ctx && req_s2_active;
    lvl_in    = (req_mode == 2'd0) ? 2'd0 : req_mode - 2'd1;
    last_beat = BW'((2 << 32'(fmt_q)) - 1);
    buf_wr    = (st_q == ST_MRSP) && mem_rsp_valid && !mem_rsp_err && (lvl_q == 2'd0);
    next_xl   = xl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pid_q   <= '0;
      fmt_q   <= FMT_BASE;
      xl_q    <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      addr_q  <= '0;
      beat_q  <= '0;
      fault_q <= 1'b0;
      cause_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            pid_q   <= req_pid;
            fmt_q   <= fmt_in;
            xl_q    <= xl_in;
            lvl_q   <= lvl_in;
            base_q  <= {req_root_ppn, 12'h000};
            beat_q  <= '0;
            fault_q <= 1'b0;
            cause_q <= '0;
            st_q    <= xl_in ? ST_XREQ : ST_MREQ;
          end
        end
        ST_XREQ: if (gpa_req_ready) st_q <= ST_XRSP;
        ST_XRSP: begin
          if (gpa_rsp_valid) begin
            if (gpa_rsp_fault) begin
              fault_q <= 1'b1;
              cause_q <= gpa_rsp_cause;
              st_q    <= ST_FIN;
            end else begin
              addr_q <= gpa_rsp_addr;
              st_q   <= ST_MREQ;
            end
          end
        end
        ST_MREQ: if (mem_req_ready) st_q <= ST_MRSP;
        ST_MRSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              fault_q <= 1'b1;
              cause_q <= CAUSE_LOAD_FAULT;
              st_q    <= ST_FIN;
            end else if (lvl_q != 2'd0) begin
              if (!ent_valid) begin
                fault_q <= 1'b1;
                cause_q <= CAUSE_NOT_VALID;
                st_q    <= ST_FIN;
              end else if (ent_rsvd) begin
                fault_q <= 1'b1;
                cause_q <= CAUSE_MISCONFIG;
                st_q    <= ST_FIN;
              end else begin
                base_q <= {ent_ppn, 12'h000};
                lvl_q  <= lvl_q - 2'd1;
                st_q   <= next_xl ? ST_XREQ : ST_MREQ;
              end
            end else if (beat_q == last_beat) begin
              beat_q <= '0;
              st_q   <= ST_EMIT;
            end else begin
              beat_q <= beat_q + 1'b1;
              st_q   <= ST_MREQ;
            end
          end
        end
        ST_EMIT: begin
          if (ctx_ready) begin
            if (beat_q == last_beat) st_q <= ST_FIN;
            else                     beat_q <= beat_q + 1'b1;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign busy          = (st_q != ST_IDLE);
  assign gpa_req_valid = (st_q == ST_XREQ);
  assign gpa_req_addr  = tgt_addr;
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_addr  = (xl_q ? addr_q : tgt_addr) + (PA_W'(beat_q) << 3);
  assign ctx_valid     = (st_q == ST_EMIT);
  assign ctx_data      = buf_rd;
  assign ctx_last      = (st_q == ST_EMIT) && (beat_q == last_beat);
  assign walk_done     = (st_q == ST_FIN);
  assign walk_fault    = (st_q == ST_FIN) && fault_q;
  assign walk_cause    = (st_q == ST_FIN) ? cause_q : '0;

endmodule

// File: rtl/pdw_walker_chk.sv
module pdw_walker_chk #(
  parameter int PA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_s2_in_ctx,
  input logic            req_msi_flat,
  input logic            req_s2_active,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            gpa_req_valid,
  input logic            ctx_valid,
  input logic            ctx_ready,
  input logic [63:0]     ctx_data,
  input logic            ctx_last,
  input logic            walk_done,
  input logic            walk_fault
);
  logic       direct_q;
  logic [3:0] beats_exp_q;
  logic [3:0] beat_cnt_q;
  logic       seen_q;
  logic [1:0] outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      direct_q    <= 1'b1;
      beats_exp_q <= 4'd2;
      beat_cnt_q  <= '0;
      seen_q      <= 1'b0;
      outst_q     <= '0;
    end else begin
      if (req_valid && req_ready) begin
        direct_q    <= req_s2_in_ctx || !req_s2_active;
        beats_exp_q <= !req_s2_in_ctx ? 4'd2 : (req_msi_flat ? 4'd8 : 4'd4);
        beat_cnt_q  <= '0;
        seen_q      <= 1'b0;
      end else if (ctx_valid && ctx_ready) begin
        beat_cnt_q <= beat_cnt_q + 4'd1;
        seen_q     <= 1'b1;
      end
      outst_q <= outst_q + 2'((mem_req_valid && mem_req_ready) ? 1 : 0)
                         - 2'(mem_rsp_valid ? 1 : 0);
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready); // R1
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R14
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> outst_q == 2'd0); // R14
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_valid && !ctx_ready |=> ctx_valid && $stable(ctx_data) && $stable(ctx_last)); // R12
  AST_NO_BEAT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |-> !seen_q); // R12
  AST_DIRECT_NO_XLT: assert property (@(posedge clk) disable iff (!rst_n)
    gpa_req_valid |-> !direct_q); // R10
  AST_BEAT_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_valid && ctx_ready && ctx_last |-> beat_cnt_q + 4'd1 == beats_exp_q); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done && !busy); // R13

endmodule

bind pdw_walker pdw_walker_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/sim_pdw_walker.sv
module sim_pdw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [55:0] XOFS = 56'h0001_0000_0000;
  localparam logic [9:0]  XCAUSE = 10'd20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_pid = '0;
  logic [43:0] req_root_ppn = '0;
  logic [1:0]  req_mode = '0;
  logic        req_s2_in_ctx = 1'b0;
  logic        req_msi_flat = 1'b0;
  logic        req_s2_active = 1'b0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        gpa_req_valid;
  logic        gpa_req_ready = 1'b0;
  logic [55:0] gpa_req_addr;
  logic        gpa_rsp_valid = 1'b0;
  logic [55:0] gpa_rsp_addr = '0;
  logic        gpa_rsp_fault = 1'b0;
  logic [9:0]  gpa_rsp_cause = '0;
  logic        ctx_valid;
  logic        ctx_ready = 1'b0;
  logic [63:0] ctx_data;
  logic        ctx_last;
  logic        walk_done;
  logic        walk_fault;
  logic [9:0]  walk_cause;

  pdw_walker u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int walk_id = 0;

  logic [63:0] mem [logic [55:0]];
  bit          err_on = 0, xf_on = 0;
  logic [55:0] err_addr = '0, xf_addr = '0;

  bit          m_pend = 0, x_pend = 0;
  int          m_dly = 0, x_dly = 0;
  logic [55:0] m_addr = '0, x_addr = '0;
  int          n_mem = 0, n_xlt = 0, n_viol = 0, nb = 0;
  logic [63:0] beats [16];
  bit          lasts [16];
  bit          done_seen = 0, got_fault = 0;
  logic [9:0]  got_cause = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [55:0] phys(input logic [55:0] a, input bit x);
    return x ? a + XOFS : a;
  endfunction

  function automatic logic [63:0] lookup(input logic [55:0] a);
    return mem.exists(a) ? mem[a] : 64'hBAD0_BAD0_BAD0_BAD0;
  endfunction

  // responders and monitor, all acting at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (m_pend) begin
        if (m_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = lookup(m_addr);
          mem_rsp_err   = err_on && (m_addr == err_addr);
          m_pend = 0;
        end else m_dly--;
      end
      if (mem_req_valid && m_pend) n_viol++;
      mem_req_ready = ($urandom % 4) != 0;
      if (mem_req_valid && mem_req_ready) begin
        m_pend = 1; m_addr = mem_req_addr; m_dly = $urandom % 3; n_mem++;
      end
      gpa_rsp_valid = 1'b0;
      gpa_rsp_fault = 1'b0;
      if (x_pend) begin
        if (x_dly == 0) begin
          gpa_rsp_valid = 1'b1;
          gpa_rsp_addr  = x_addr + XOFS;
          gpa_rsp_fault = xf_on && (x_addr == xf_addr);
          gpa_rsp_cause = XCAUSE;
          x_pend = 0;
        end else x_dly--;
      end
      gpa_req_ready = ($urandom % 3) != 0;
      if (gpa_req_valid && gpa_req_ready) begin
        x_pend = 1; x_addr = gpa_req_addr; x_dly = $urandom % 3; n_xlt++;
      end
      ctx_ready = ($urandom % 3) != 0;
      if (ctx_valid && ctx_ready && nb < 16) begin
        beats[nb] = ctx_data; lasts[nb] = ctx_last; nb++;
      end
      if (walk_done) begin
        done_seen = 1; got_fault = walk_fault; got_cause = walk_cause;
      end
    end
  end

  // fkind: 0 none, 1 entry not valid, 2 reserved bit, 3 read error, 4 translation fault
  task automatic run_walk(input logic [19:0] pid, input int mode, input bit s2c,
                          input bit msi, input bit s2a, input int fkind, input int flvl);
    int levels, fmt, w0, w2, nbeat, rsz, wcnt, exp_cause;
    int p;
    int pdi [3];
    bit xl, stop, exp_fault;
    logic [43:0] root, ppn;
    logic [55:0] base, ea, la;
    logic [63:0] ent;
    logic [63:0] expd [8];
    string ftag, rtag;
    walk_id++;
    mem.delete();
    err_on = 0; xf_on = 0;
    levels = (mode == 0) ? 1 : mode;
    fmt = s2c ? (msi ? 2 : 1) : 0;
    rtag = (fmt == 0) ? "R3" : ((fmt == 1) ? "R4" : "R5");
    w0 = 8 - fmt; w2 = 3 + fmt; nbeat = 2 << fmt; rsz = 16 << fmt;
    p = int'(pid);
    pdi[0] = p & ((1 << w0) - 1);
    pdi[1] = (p >> w0) & 511;
    pdi[2] = (p >> (w0 + 9)) & ((1 << w2) - 1);
    xl = !s2c && s2a;
    root = (44'(walk_id) << 4) + 44'h100;
    base = {root, 12'h000};
    exp_fault = 0; exp_cause = 0; stop = 0;
    case (fkind)
      1: ftag = "R7";
      2: ftag = "R8";
      3: ftag = "R9";
      4: ftag = "R11";
      default: ftag = "R13";
    endcase
    for (int i = levels - 1; i >= 1; i--) begin
      if (!stop) begin
        ea  = base + 56'(pdi[i] * 8);
        ppn = root + 44'(i);
        ent = {10'h000, ppn, 9'h000, 1'b1};
        if (fkind != 0 && flvl == i) begin
          stop = 1; exp_fault = 1;
          case (fkind)
            1: begin ent[0] = 1'b0; exp_cause = 266; end
            2: begin ent[(($urandom % 2) != 0) ? 5 : 58] = 1'b1; exp_cause = 267; end
            3: begin err_on = 1; err_addr = phys(ea, xl); exp_cause = 265; end
            default: begin xf_on = 1; xf_addr = ea; exp_cause = int'(XCAUSE); end
          endcase
        end
        mem[phys(ea, xl)] = ent;
        base = {ppn, 12'h000};
      end
    end
    if (!stop) begin
      la = base + 56'(pdi[0] * rsz);
      for (int k = 0; k < nbeat; k++) begin
        expd[k] = {$urandom, $urandom};
        mem[phys(la, xl) + 56'(8 * k)] = expd[k];
      end
      if (fkind == 3 && flvl == 0) begin
        err_on = 1; err_addr = phys(la, xl) + 56'((nbeat - 1) * 8);
        exp_fault = 1; exp_cause = 265;
      end
      if (fkind == 4 && flvl == 0) begin
        xf_on = 1; xf_addr = la; exp_fault = 1; exp_cause = int'(XCAUSE);
      end
    end
    n_mem = 0; n_xlt = 0; nb = 0; done_seen = 0;
    @(negedge clk);
    req_pid = pid; req_root_ppn = root; req_mode = 2'(mode);
    req_s2_in_ctx = s2c; req_msi_flat = msi; req_s2_active = s2a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R1", "busy after accept", {62'd0, busy, req_ready}, 64'd2);
    wcnt = 0;
    while (!done_seen && wcnt < 3000) begin
      @(negedge clk);
      wcnt++;
    end
    chk(done_seen, "R13", "walk completion seen", 64'(done_seen), 64'd1);
    chk(got_fault == exp_fault, ftag, "fault flag", 64'(got_fault), 64'(exp_fault));
    chk(got_cause == 10'(exp_cause), ftag, "cause", 64'(got_cause), 64'(exp_cause));
    if (exp_fault) begin
      chk(nb == 0, "R12", "no beats on fault", 64'(nb), 64'd0);
    end else begin
      chk(nb == nbeat, rtag, "beat count", 64'(nb), 64'(nbeat));
      for (int k = 0; k < nb && k < nbeat; k++) begin
        chk(beats[k] == expd[k], "R6", "record doubleword", beats[k], expd[k]);
        chk(lasts[k] == (k == nbeat - 1), "R12", "last flag", 64'(lasts[k]), 64'(k == nbeat - 1));
      end
      chk(n_mem == levels - 1 + nbeat, "R2", "memory read count", 64'(n_mem), 64'(levels - 1 + nbeat));
      chk(n_xlt == (xl ? levels : 0), "R10", "translation count", 64'(n_xlt), 64'(xl ? levels : 0));
    end
    chk(n_viol == 0, "R14", "read issued while one outstanding", 64'(n_viol), 64'd0);
    @(negedge clk);
    chk(req_ready && !busy, "R13", "idle after done", {62'd0, req_ready, busy}, 64'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !gpa_req_valid && !ctx_valid && !walk_done,
        "R1", "outputs quiet in reset", {59'd0, busy, mem_req_valid, gpa_req_valid, ctx_valid, walk_done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy, "R1", "idle after reset", {62'd0, req_ready, busy}, 64'd2);

    // every layout at every depth, direct addressing
    for (int f = 0; f < 3; f++)
      for (int m = 1; m <= 3; m++)
        run_walk(20'h5A3C7 + 20'(m * 97 + f), m, f != 0, f == 2, 1'b0, 0, 0);
    // mode 0 acts as one level; max indices; MSI flag alone
    run_walk(20'h000AB, 0, 1'b0, 1'b0, 1'b0, 0, 0);
    run_walk(20'hFFFFF, 3, 1'b0, 1'b0, 1'b0, 0, 0);
    run_walk(20'hFFFFF, 3, 1'b1, 1'b0, 1'b0, 0, 0);
    run_walk(20'hFFFFF, 3, 1'b1, 1'b1, 1'b0, 0, 0);
    run_walk(20'h12345, 3, 1'b0, 1'b1, 1'b0, 0, 0);   // R5 MSI flag alone
    // translated and untranslated with second stage active
    for (int m = 1; m <= 3; m++) run_walk(20'h31415 + 20'(m), m, 1'b0, 1'b0, 1'b1, 0, 0);
    run_walk(20'h27182, 3, 1'b1, 1'b0, 1'b1, 0, 0);   // R10 pointer used directly
    run_walk(20'h27183, 2, 1'b1, 1'b1, 1'b1, 0, 0);
    // faults
    run_walk(20'h0F0F0, 3, 1'b0, 1'b0, 1'b0, 1, 2);   // R7
    run_walk(20'h0F0F1, 3, 1'b1, 1'b0, 1'b0, 1, 1);
    run_walk(20'h0F0F2, 2, 1'b0, 1'b0, 1'b0, 2, 1);   // R8
    run_walk(20'h0F0F3, 3, 1'b0, 1'b0, 1'b0, 3, 2);   // R9 on an entry
    run_walk(20'h0F0F4, 2, 1'b1, 1'b1, 1'b0, 3, 0);   // R9 on the last leaf beat
    run_walk(20'h0F0F5, 3, 1'b0, 1'b0, 1'b1, 4, 1);   // R11 on an entry
    run_walk(20'h0F0F6, 1, 1'b0, 1'b0, 1'b1, 4, 0);   // R11 on the leaf
    // random mix
    for (int t = 0; t < 60; t++) begin
      int m, fk, fl, lv;
      bit s2c, msi, s2a;
      m = (($urandom % 8) == 0) ? 0 : 1 + int'($urandom % 3);
      lv = (m == 0) ? 1 : m;
      s2c = $urandom % 2; msi = $urandom % 2; s2a = $urandom % 2;
      fk = (($urandom % 2) == 0) ? 0 : 1 + int'($urandom % 4);
      if ((fk == 1 || fk == 2) && lv == 1) fk = 0;
      if (fk == 4 && !( !s2c && s2a)) fk = 0;
      fl = (fk == 1 || fk == 2) ? 1 + int'($urandom % (lv - 1)) : int'($urandom % lv);
      run_walk(20'($urandom), m, s2c, msi, s2a, fk, fl);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule